// File: doc/BRIEF.md
# MDIO Clause 22 Management Master

This block is the station-management master of an Ethernet MAC. Software sees two 32-bit registers through a plain read/write port: a command word and a configuration word. A single command write supplies the operation code, the PHY address, the register address and, for writes, the 16 data bits. If the same write also sets the start bit, the block clocks a Clause 22 management frame out on the MDC/MDIO pins, and it holds the start bit at 1 while the frame runs.

A frame begins with 32 preamble ones, which the configuration word can suppress. Next come the start pattern, the operation code, both addresses, a two-bit turnaround and 16 data bits. MDC is made by dividing the reference clock by 2×(N+1). MDIO changes after a falling MDC edge and is sampled on a rising one.

On a read, the block releases MDIO for the turnaround and checks that the PHY pulls the second turnaround bit low. It then shifts in the 16 data bits and places them in the low half of the command word once the start bit clears. Software polls the start bit to learn when the frame is complete.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: Command word at offset 0x00. Its layout is: bit 29 start/busy, bit 28 read-fail (read-only), bits 27:26 opcode (01 write, 10 read), bits 25:21 PHY address, bits 20:16 register address, bits 15:0 data. Bits 31:30 read 0. A command write while idle stores all fields. The write launches a frame only when bit 29 is 1, and busy then reads 1 on the cycle after the write.
- R2: Let B be 64 with the preamble or 32 without it. Busy stays 1 for exactly 2·B·(N+1) reference cycles after the launching write, then clears. It clears on the same cycle as the final rising MDC edge.
- R3: Configuration word at offset 0x04. Bit 0 is the Clause 22 select (reset 1), bits 9:4 are the divider N (reset 4), bit 12 suppresses the preamble (reset 0), and all other bits read 0. The command word resets to 0. Any other offset reads 0.
- R4: The serial frame, each field MSB first, is: preamble ones (unless suppressed), start 01, opcode, PHY address, register address, turnaround, data. The turnaround is driven as 10 on a write. MDIO only changes on a falling MDC edge.
- R5: MDC idles high. While a frame runs, every MDC level lasts exactly N+1 reference cycles, and the first fall comes N+1 cycles after the launch.
- R6: On a read (opcode 10), the output enable drops from the first turnaround bit to the end of the frame. The 16 bits sampled on the rising edges of the data phase are placed in bits 15:0 when busy clears. This happens even if the read failed.
- R7: The read-fail flag sets when the PHY leaves MDIO high at the rising edge of the second turnaround bit of a read. It is cleared by the next launch and never sets on a write.
- R8: A command write while busy is 1 is ignored completely: no field changes, no relaunch, and the frame in flight is unchanged.
- R9: The divider and the preamble-suppress bit are taken when a frame launches. A configuration write during a frame shows in the register but does not alter that frame.
- R10: While idle, the MDIO output enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register byte offset (0x00 command, 0x04 configuration) |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (pad driven when 1) |
| mdio_i | input | 1 | MDIO value seen at the pad |

## Verification
Busy is due exactly 2·B·(N+1) cycles after the launching edge. The bench counts falling clock edges from that edge and reads the busy bit one cycle before and on that cycle. Every MDC transition must come N+1 cycles after the previous one (or after the launch), so the bench timestamps each transition and compares the gap. Serial bits and enables are captured on the cycle of each MDC fall, where both are updated. Read data and the fail flag are read back only after busy has cleared.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam int REG_W     = 32;
    localparam int DIV_W     = 6;
    localparam int PRE_BITS  = 32;
    localparam int FRM_BITS  = 32;
    localparam int POS_W     = $clog2(PRE_BITS + FRM_BITS + 1);

    localparam int CMD_OFS   = 0;
    localparam int CFG_OFS   = 4;

    localparam int CMD_GO_BIT   = 29;
    localparam int CMD_FAIL_BIT = 28;
    localparam int CMD_OP_LSB   = 26;
    localparam int CMD_PHY_LSB  = 21;
    localparam int CMD_REG_LSB  = 16;

    localparam int CFG_C22_BIT  = 0;
    localparam int CFG_DIV_LSB  = 4;
    localparam int CFG_SUPP_BIT = 12;

    // frame positions counted from the first preamble bit
    localparam int POS_LAST     = PRE_BITS + FRM_BITS - 1;
    localparam int POS_TA_FIRST = PRE_BITS + 14;
    localparam int POS_TA_CHECK = PRE_BITS + 15;
    localparam int POS_DATA     = PRE_BITS + 16;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_RSVD  = 2'b11
    } mdio_op_e;

    typedef struct packed {
        mdio_op_e    op;
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [15:0] data;
    } mdio_cmd_t;

    typedef struct packed {
        logic             supp;
        logic [DIV_W-1:0] div;
        logic             c22;
    } mdio_cfg_t;

    function automatic mdio_cmd_t cmd_from_word(input logic [REG_W-1:0] w);
        mdio_cmd_t c;
        c.op    = mdio_op_e'(w[CMD_OP_LSB +: 2]);
        c.phy   = w[CMD_PHY_LSB +: 5];
        c.regad = w[CMD_REG_LSB +: 5];
        c.data  = w[15:0];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] cmd_to_word(input mdio_cmd_t c,
                                                     input logic busy,
                                                     input logic fail);
        logic [REG_W-1:0] w;
        w = '0;
        w[CMD_GO_BIT]            = busy;
        w[CMD_FAIL_BIT]          = fail;
        w[CMD_OP_LSB +: 2]       = c.op;
        w[CMD_PHY_LSB +: 5]      = c.phy;
        w[CMD_REG_LSB +: 5]      = c.regad;
        w[15:0]                  = c.data;
        return w;
    endfunction

    function automatic mdio_cfg_t cfg_from_word(input logic [REG_W-1:0] w);
        mdio_cfg_t c;
        c.supp = w[CFG_SUPP_BIT];
        c.div  = w[CFG_DIV_LSB +: DIV_W];
        c.c22  = w[CFG_C22_BIT];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] cfg_to_word(input mdio_cfg_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[CFG_SUPP_BIT]          = c.supp;
        w[CFG_DIV_LSB +: DIV_W]  = c.div;
        w[CFG_C22_BIT]           = c.c22;
        return w;
    endfunction

    // the 32 bits after the preamble, first bit sent in bit 31
    function automatic logic [FRM_BITS-1:0] frame_word(input mdio_cmd_t c);
        logic [1:0] ta;
        ta = (c.op == OP_READ) ? 2'b11 : 2'b10;
        return {2'b01, c.op, c.phy, c.regad, ta, c.data};
    endfunction

endpackage

// File: rtl/mdio_mgmt_regs.sv
module mdio_mgmt_regs
    import mdio_mgmt_pkg::*;
#(
    parameter int ADDR_W  = 3,
    parameter int RST_DIV = 4,
    parameter bit RST_C22 = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wen,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              done,
    input  logic              ta_fail,
    input  logic [15:0]       rd_word,
    output logic              start,
    output mdio_cmd_t         start_cmd,
    output mdio_cmd_t         cmd,
    output logic [DIV_W-1:0]  div,
    output logic              supp,
    output logic              busy,
    output logic              fail
);

    localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(CMD_OFS);
    localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(CFG_OFS);

    mdio_cmd_t cmd_q;
    mdio_cfg_t cfg_q;
    logic      busy_q, fail_q;
    logic      cmd_wr, cfg_wr;

    assign cmd_wr    = reg_wen && (reg_addr == A_CMD) && !busy_q;
    assign cfg_wr    = reg_wen && (reg_addr == A_CFG);
    assign start     = cmd_wr && reg_wdata[CMD_GO_BIT];
    assign start_cmd = cmd_from_word(reg_wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '{op: OP_NONE, phy: '0, regad: '0, data: '0};
            cfg_q  <= '{supp: 1'b0, div: DIV_W'(RST_DIV), c22: RST_C22};
            busy_q <= 1'b0;
            fail_q <= 1'b0;
        end else begin
            if (cmd_wr)
                cmd_q <= start_cmd;
            else if (done && cmd_q.op == OP_READ)
                cmd_q.data <= rd_word;

            if (cfg_wr)
                cfg_q <= cfg_from_word(reg_wdata);

            if (start)
                busy_q <= 1'b1;
            else if (done)
                busy_q <= 1'b0;

            if (start)
                fail_q <= 1'b0;
            else if (ta_fail)
                fail_q <= 1'b1;
        end
    end

    always_comb begin
        unique case (reg_addr)
            A_CMD:   reg_rdata = cmd_to_word(cmd_q, busy_q, fail_q);
            A_CFG:   reg_rdata = cfg_to_word(cfg_q);
            default: reg_rdata = '0;
        endcase
    end

    assign cmd  = cmd_q;
    assign div  = cfg_q.div;
    assign supp = cfg_q.supp;
    assign busy = busy_q;
    assign fail = fail_q;

endmodule

// File: rtl/mdio_mgmt_clkgen.sv
module mdio_mgmt_clkgen #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             fall_evt,
    output logic             rise_evt
);

    logic [DIV_W-1:0] cnt_q, div_q;
    logic             mdc_q;
    logic             tc;

    assign tc       = run && (cnt_q == div_q);
    assign fall_evt = tc && mdc_q;
    assign rise_evt = tc && !mdc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            div_q <= '0;
            mdc_q <= 1'b1;
        end else if (start) begin
            cnt_q <= '0;
            div_q <= div;
            mdc_q <= 1'b1;
        end else if (tc) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else if (run) begin
            cnt_q <= cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
            mdc_q <= 1'b1;
        end
    end

    assign mdc = mdc_q;

endmodule

// File: rtl/mdio_mgmt_shifter.sv
module mdio_mgmt_shifter
    import mdio_mgmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  mdio_cmd_t   start_cmd,
    input  logic        supp,
    input  logic        fall_evt,
    input  logic        rise_evt,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        done,
    output logic        ta_fail,
    output logic [15:0] rd_word
);

    localparam logic [POS_W-1:0] P_PRE   = POS_W'(PRE_BITS);
    localparam logic [POS_W-1:0] P_LAST  = POS_W'(POS_LAST);
    localparam logic [POS_W-1:0] P_TA0   = POS_W'(POS_TA_FIRST);
    localparam logic [POS_W-1:0] P_TA1   = POS_W'(POS_TA_CHECK);
    localparam logic [POS_W-1:0] P_DATA  = POS_W'(POS_DATA);

    logic [FRM_BITS-1:0] frame_q;
    logic [POS_W-1:0]    nxt_q, cur_q;
    logic                rd_q, mdo_q, oe_q;
    logic [14:0]         sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= '0;
            nxt_q   <= '0;
            cur_q   <= '0;
            rd_q    <= 1'b0;
            mdo_q   <= 1'b1;
            oe_q    <= 1'b0;
            sh_q    <= '0;
        end else if (start) begin
            frame_q <= frame_word(start_cmd);
            nxt_q   <= supp ? P_PRE : '0;
            cur_q   <= '0;
            rd_q    <= (start_cmd.op == OP_READ);
        end else if (fall_evt) begin
            cur_q <= nxt_q;
            nxt_q <= nxt_q + 1'b1;
            oe_q  <= !(rd_q && nxt_q >= P_TA0);
            if (nxt_q >= P_PRE) begin
                mdo_q   <= frame_q[FRM_BITS-1];
                frame_q <= {frame_q[FRM_BITS-2:0], 1'b0};
            end else begin
                mdo_q <= 1'b1;
            end
        end else if (rise_evt) begin
            if (rd_q && cur_q >= P_DATA)
                sh_q <= {sh_q[13:0], mdio_i};
            if (cur_q == P_LAST)
                oe_q <= 1'b0;
        end
    end

    assign done    = rise_evt && (cur_q == P_LAST);
    assign ta_fail = rise_evt && rd_q && (cur_q == P_TA1) && mdio_i;
    assign rd_word = {sh_q, mdio_i};
    assign mdio_o  = mdo_q;
    assign mdio_oe = oe_q;

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_mgmt_pkg::*;
#(
    parameter int ADDR_W  = 3,
    parameter int RST_DIV = 4,
    parameter bit RST_C22 = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wen,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);

    logic             start_w, busy_w, fail_w, done_w, ta_fail_w;
    logic             fall_w, rise_w, supp_w;
    logic [DIV_W-1:0] div_w;
    logic [15:0]      rd_word_w;
    mdio_cmd_t        start_cmd_w, cmd_w;

    mdio_mgmt_regs #(
        .ADDR_W  (ADDR_W),
        .RST_DIV (RST_DIV),
        .RST_C22 (RST_C22)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_wen   (reg_wen),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .done      (done_w),
        .ta_fail   (ta_fail_w),
        .rd_word   (rd_word_w),
        .start     (start_w),
        .start_cmd (start_cmd_w),
        .cmd       (cmd_w),
        .div       (div_w),
        .supp      (supp_w),
        .busy      (busy_w),
        .fail      (fail_w)
    );

    mdio_mgmt_clkgen #(
        .DIV_W (DIV_W)
    ) u_clkgen (
        .clk      (clk),
        .rst      (rst),
        .start    (start_w),
        .run      (busy_w),
        .div      (div_w),
        .mdc      (mdc),
        .fall_evt (fall_w),
        .rise_evt (rise_w)
    );

    mdio_mgmt_shifter u_shifter (
        .clk       (clk),
        .rst       (rst),
        .start     (start_w),
        .start_cmd (start_cmd_w),
        .supp      (supp_w),
        .fall_evt  (fall_w),
        .rise_evt  (rise_w),
        .mdio_i    (mdio_i),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .done      (done_w),
        .ta_fail   (ta_fail_w),
        .rd_word   (rd_word_w)
    );

endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker
    import mdio_mgmt_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      start,
    input logic      busy,
    input logic      fail,
    input mdio_cmd_t cmd,
    input logic      mdc,
    input logic      mdio_o,
    input logic      mdio_oe
);

    // R1: a launch raises busy on the next cycle
    assert_launch_sets_busy_R1: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

    // R2: busy only ends together with a rising MDC edge
    assert_busy_ends_on_rise_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $rose(mdc));

    // R4: the output bit is never changed while MDC is high
    assert_out_moves_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
        mdc |-> $stable(mdio_o));

    // R5: MDC rests high when no frame runs
    assert_mdc_idle_high_R5: assert property (@(posedge clk) disable iff (rst)
        !busy |-> mdc);

    // R7: fail flag is cleared by a launch
    assert_fail_cleared_R7: assert property (@(posedge clk) disable iff (rst)
        start |=> !fail);

    // R7: fail flag only rises on a read
    assert_fail_only_read_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(fail) |-> cmd.op == OP_READ);

    // R8: command fields hold while a frame runs
    assert_cmd_hold_busy_R8: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(cmd.op) && $stable(cmd.phy) && $stable(cmd.regad)));

    // R10: pad not driven while idle
    assert_idle_no_drive_R10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdio_oe);

endmodule

bind mdio_mgmt_ctrl mdio_mgmt_checker i_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start_w),
    .busy    (busy_w),
    .fail    (fail_w),
    .cmd     (cmd_w),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
);

// File: tb/test_mdio_mgmt_ctrl.sv
`timescale 1ns/1ps
module test_mdio_mgmt_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  reg_addr = 3'd0;
    logic        reg_wen = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    always #5 clk = ~clk;

    mdio_mgmt_ctrl i_mdio_mgmt_ctrl (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_wen   (reg_wen),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i)
    );

    typedef struct packed {
        logic [5:0]  div;
        logic        supp;
        logic [1:0]  op;
        logic [4:0]  phy;
        logic [4:0]  ra;
        logic [15:0] wd;
        logic        ta_bad;
        logic [15:0] prd;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{6'd0, 1'b0, 2'b01, 5'h01, 5'h00, 16'h1140, 1'b0, 16'h0000},
        '{6'd1, 1'b1, 2'b01, 5'h1F, 5'h1F, 16'hA55A, 1'b0, 16'h0000},
        '{6'd0, 1'b0, 2'b10, 5'h03, 5'h02, 16'h0000, 1'b0, 16'h0141},
        '{6'd2, 1'b1, 2'b10, 5'h10, 5'h0A, 16'hFFFF, 1'b0, 16'hBEEF},
        '{6'd0, 1'b1, 2'b10, 5'h07, 5'h01, 16'h0000, 1'b1, 16'h7FFE},
        '{6'd3, 1'b0, 2'b01, 5'h00, 5'h10, 16'h0001, 1'b0, 16'h0000}
    };

    int n_chk = 0;
    int n_fail = 0;

    // monitor / PHY model state
    logic        mon_on = 1'b0;
    logic        mdc_prev = 1'b1;
    int          obs_n;
    logic [63:0] obs_b, obs_e;
    longint      last_t, exp_half;
    int          bad_int;
    int          cur_b;
    logic        cur_rd, cur_tab;
    logic [15:0] cur_prd;

    function automatic logic phy_bit(input int k);
        int pos;
        pos = k - (cur_b - 32);
        if (!cur_rd) return 1'b1;
        if (pos == 15) return cur_tab;
        if (pos >= 16 && pos <= 31) return cur_prd[31 - pos];
        return 1'b1;
    endfunction

    always @(negedge clk) begin
        if (mon_on && (mdc !== mdc_prev)) begin
            if (($time - 5 - last_t) != exp_half) bad_int++;
            last_t = $time - 5;
            if (!mdc) begin
                if (obs_n < 64) begin
                    obs_b[obs_n] = mdio_o;
                    obs_e[obs_n] = mdio_oe;
                end
                mdio_i = phy_bit(obs_n);
                obs_n++;
            end
        end
        mdc_prev = mdc;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wen   = 1'b1;
        @(negedge clk);
        reg_wen   = 1'b0;
        reg_addr  = 3'd0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
        reg_addr = 3'd0;
    endtask

    function automatic logic [31:0] cfg_word(input logic [5:0] dv, input logic sp);
        return {19'b0, sp, 2'b00, dv, 3'b000, 1'b1};
    endfunction

    // inj: 0 none, 1 command write mid-frame, 2 configuration write mid-frame
    task automatic run_vec(input vec_t v, input int inj, input logic [31:0] inj_word);
        int          nb, dur, pos;
        logic        is_rd, efail;
        logic [31:0] fw, rv;
        logic [63:0] eb, ee;
        logic [15:0] edata;
        nb    = v.supp ? 32 : 64;
        dur   = 2 * nb * (int'(v.div) + 1);
        is_rd = (v.op == 2'b10);
        wr(3'd4, cfg_word(v.div, v.supp));
        cur_b = nb; cur_rd = is_rd; cur_tab = v.ta_bad; cur_prd = v.prd;
        obs_n = 0; obs_b = '0; obs_e = '0; bad_int = 0;
        exp_half = (longint'(v.div) + 1) * 10;
        mon_on = 1'b1;
        @(negedge clk);
        reg_addr  = 3'd0;
        reg_wdata = {2'b00, 1'b1, 1'b0, v.op, v.phy, v.ra, v.wd};
        reg_wen   = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0;
        last_t  = $time - 5;
        for (int c = 1; c < dur; c++) begin
            if (c == 9 && inj != 0) begin
                reg_addr  = (inj == 1) ? 3'd0 : 3'd4;
                reg_wdata = inj_word;
                reg_wen   = 1'b1;
            end
            if (c == 10) begin
                reg_wen  = 1'b0;
                reg_addr = 3'd0;
            end
            @(negedge clk);
        end
        rd(3'd0, rv);
        chk("R2 busy still set one cycle before end", 64'(rv[29]), 64'd1);
        @(negedge clk);
        rd(3'd0, rv);
        chk("R2 busy clears after 2*B*(N+1) cycles", 64'(rv[29]), 64'd0);
        mon_on = 1'b0;
        mdio_i = 1'b1;
        // expected serial stream
        fw = {2'b01, v.op, v.phy, v.ra, (is_rd ? 2'b11 : 2'b10), v.wd};
        eb = '0; ee = '0;
        for (int k = 0; k < nb; k++) begin
            pos = k - (nb - 32);
            eb[k] = (pos < 0) ? 1'b1 : fw[31 - pos];
            ee[k] = is_rd ? (pos < 14) : 1'b1;
        end
        chk("R4 number of MDC falls", 64'(obs_n), 64'(nb));
        chk("R4 serial bits where driven", obs_b & ee, eb & ee);
        chk("R6 output enable per bit", obs_e, ee);
        chk("R5 every MDC level lasts N+1 cycles", 64'(bad_int), 64'd0);
        chk("R5 MDC high after frame", 64'(mdc), 64'd1);
        chk("R10 enable low after frame", 64'(mdio_oe), 64'd0);
        efail = is_rd && v.ta_bad;
        edata = is_rd ? v.prd : v.wd;
        chk("R1 R6 R7 command word after frame", 64'(rv),
            64'({2'b00, 1'b0, efail, v.op, v.phy, v.ra, edata}));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R2 act=running exp=finished");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state (R3, R5, R10)
        rd(3'd0, rv);
        chk("R3 command word reset", 64'(rv), 64'd0);
        rd(3'd4, rv);
        chk("R3 configuration reset", 64'(rv), 64'(cfg_word(6'd4, 1'b0)));
        rd(3'd6, rv);
        chk("R3 unused offset reads zero", 64'(rv), 64'd0);
        chk("R5 MDC idles high after reset", 64'(mdc), 64'd1);
        chk("R10 enable low after reset", 64'(mdio_oe), 64'd0);

        // R1: write without start bit stores fields, fail bit is read-only
        wr(3'd0, {2'b00, 1'b0, 1'b1, 2'b10, 5'h0A, 5'h05, 16'h1234});
        repeat (20) @(negedge clk);
        rd(3'd0, rv);
        chk("R1 fields stored, no launch", 64'(rv),
            64'({2'b00, 1'b0, 1'b0, 2'b10, 5'h0A, 5'h05, 16'h1234}));
        chk("R1 no MDC activity without start", 64'(mdc), 64'd1);

        // R3: configuration readback keeps only its fields
        wr(3'd4, 32'hFFFF_FFFF);
        rd(3'd4, rv);
        chk("R3 configuration field mask", 64'(rv), 64'h0000_13F1);

        // vector table
        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i], 0, 32'd0);
        end

        // R8: command write during a frame is ignored
        run_vec('{6'd0, 1'b1, 2'b01, 5'h02, 5'h03, 16'hCAFE, 1'b0, 16'h0000},
                1, {2'b00, 1'b1, 1'b0, 2'b10, 5'h1F, 5'h1E, 16'h5555});

        // R9: configuration write during a frame does not alter it
        run_vec('{6'd1, 1'b0, 2'b01, 5'h04, 5'h05, 16'h0F0F, 1'b0, 16'h0000},
                2, cfg_word(6'd0, 1'b1));
        rd(3'd4, rv);
        chk("R9 configuration shows mid-frame write", 64'(rv),
            64'(cfg_word(6'd0, 1'b1)));

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule